// File: doc/BRIEF.md
# Single-Pulse Fixed-Frequency PWM with Blanked Current Limit

The block is the digital core of a fixed-frequency pulse-width modulator for a switching power stage. A free-running counter stands in for a sawtooth. Each period starts with a fixed charge segment in which the gate is always held off. A falling segment follows, and it is the only part of the period in which conduction can take place. A set/reset latch turns the switch on at the ramp peak. It turns the switch off again when the falling ramp passes the level given by an 8-bit feedback code, or when a current-limit flag is seen outside the blanking window that follows every turn-on.

Once the latch has cleared, it cannot be set again before the next peak, so each period carries at most one pulse. A supervisor enable removes the gate drive at once and empties the latch. A cycle-start strobe marks the peak of each period, so neighbouring logic can align with the switching frame. The analog sense paths, the feedback filter and the gate driver are outside this block.

Top module: `gpwm_top`

## Requirements
- R1: The period is PERIOD = 1000 clock ticks. `cyc_start_o` is high for exactly one tick per period, so successive strobes are 1000 ticks apart.
- R2: The first CHARGE = 280 ticks of every period form the charge segment, and the gate is low throughout it. The longest pulse is therefore 720 ticks (72 % duty).
- R3: The gate rises in the same tick as the strobe. It stays high for exactly floor((255 - F) * 720 / 255) ticks, where F is the unsigned feedback code on `fb_code_i`: code 0 gives 720 ticks, code 255 gives no pulse, and the duty is linear in between.
- R4: After the gate falls in a period, it stays low until the next strobe, even if the feedback code or the current-limit flag later changes back.
- R5: If `ilim_i` is high in a tick where the gate is high and the blanking window has ended, the gate is low from the following tick for the rest of the period.
- R6: The first BLANK = 20 ticks of each pulse are blanked. `ilim_i` has no effect in them, so a flag that is held high all the time gives a pulse of BLANK + 1 = 21 ticks, or a shorter pulse if the feedback code ends it first.
- R7: While `en_i` is low, `gate_o` is low in the same tick and the latch is cleared. When enable returns in the middle of a period, the gate stays low until the next strobe.
- R8: While `rst_n` is low, `gate_o` and `cyc_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal (10 ns tick) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en_i | input | 1 | Supervisor enable; low forces the gate off |
| fb_code_i | input | 8 | Feedback level; 0 = ramp valley (full duty), 255 = ramp peak (no duty) |
| ilim_i | input | 1 | Current-limit flag, active high |
| gate_o | output | 1 | Power-switch gate drive, active high |
| cyc_start_o | output | 1 | One-tick strobe at the ramp peak of each period |

## Verification
The assertions check on every cycle that the counter wraps at the period end, that the gate never conducts in the charge segment, that a cleared latch stays cleared until the peak, that enable low empties the latch, and that an unblanked current limit ends the pulse while a blanked one does not. Only the bench scenarios can show the exact pulse widths across the sweep of feedback codes, the 1000-tick strobe spacing seen at the ports, and the boundary at the last blanked tick. They also show that a code change back to a low level or a returning enable does not produce a second pulse.

// File: rtl/gpwm_pkg.sv
package gpwm_pkg;
  typedef enum logic {
    SEG_CHARGE    = 1'b0,
    SEG_DISCHARGE = 1'b1
  } seg_e;
endpackage

// File: rtl/gpwm_ramp.sv
module gpwm_ramp #(
  parameter int PERIOD = 1000,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  always_comb begin
    if (cnt_q == LAST) cnt_nxt = '0;
    else               cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R1: the counter wraps exactly at the period end and steps by one otherwise
  assert_period_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
  assert_period_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_period_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST));
endmodule

// File: rtl/gpwm_level.sv
module gpwm_level #(
  parameter int FB_W     = 8,
  parameter int CNT_W    = 10,
  parameter int ON_TICKS = 720
) (
  input  logic [FB_W-1:0]  fb_code,
  output logic [CNT_W-1:0] on_ticks
);
  localparam int PROD_W = FB_W + CNT_W;
  localparam int FB_MAX = (1 << FB_W) - 1;

  logic [FB_W-1:0]   fb_inv;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  // distance from the peak, scaled onto the falling segment
  always_comb begin
    fb_inv   = ~fb_code;
    prod     = PROD_W'(fb_inv) * PROD_W'(ON_TICKS);
    quot     = prod / PROD_W'(FB_MAX);
    on_ticks = CNT_W'(quot);
  end
endmodule

// File: rtl/gpwm_latch.sv
module gpwm_latch
  import gpwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int CHARGE = 280,
  parameter int BLANK  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] on_ticks,
  input  logic             ilim_i,
  input  logic             en_i,
  output logic             q_o
);
  localparam logic [CNT_W-1:0] CHG_C = CNT_W'(CHARGE);
  localparam logic [CNT_W-1:0] BLK_C = CNT_W'(BLANK);

  seg_e             seg_nxt;
  logic             peak_nxt;
  logic [CNT_W-1:0] pos_nxt;
  logic [CNT_W-1:0] pos_cur;
  logic             blank_act;
  logic             ramp_off;
  logic             q_r;
  logic             q_n;

  always_comb begin
    seg_nxt   = (cnt_nxt < CHG_C) ? SEG_CHARGE : SEG_DISCHARGE;
    peak_nxt  = (cnt_nxt == CHG_C);
    pos_nxt   = cnt_nxt - CHG_C;
    pos_cur   = cnt_q - CHG_C;
    blank_act = (cnt_q >= CHG_C) && (pos_cur < BLK_C);
    ramp_off  = (seg_nxt == SEG_CHARGE) || (pos_nxt >= on_ticks);
  end

  // next state: set only at the peak, cleared by ramp, limit, enable or charge
  always_comb begin
    q_n = q_r;
    if (!en_i)                          q_n = 1'b0;
    else if (seg_nxt == SEG_CHARGE)     q_n = 1'b0;
    else if (peak_nxt)                  q_n = (on_ticks != '0);
    else if (q_r && ramp_off)           q_n = 1'b0;
    else if (q_r && ilim_i && !blank_act) q_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_n;
  end

  assign q_o = q_r;

  // R2: no conduction in the charge segment
  assert_charge_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CHG_C) |-> !q_r);
  // R4: a cleared latch stays cleared unless the peak is next
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_r && !peak_nxt) |=> !q_r);
  // R5: an unblanked limit ends the pulse
  assert_ilim_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r && ilim_i && !blank_act) |=> !q_r);
  // R6: inside the blanking window only ramp or enable may end the pulse
  assert_blank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r && blank_act && en_i && !ramp_off) |=> q_r);
  // R7: enable low empties the latch
  assert_en_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !q_r);
endmodule

// File: rtl/gpwm_top.sv
module gpwm_top #(
  parameter int PERIOD = 1000,
  parameter int CHARGE = 280,
  parameter int BLANK  = 20,
  parameter int FB_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [FB_W-1:0] fb_code_i,
  input  logic            ilim_i,
  output logic            gate_o,
  output logic            cyc_start_o
);
  localparam int CNT_W    = $clog2(PERIOD);
  localparam int ON_TICKS = PERIOD - CHARGE;
  localparam logic [CNT_W-1:0] CHG_C = CNT_W'(CHARGE);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] on_ticks;
  logic             latch_q;

  gpwm_ramp #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  gpwm_level #(.FB_W(FB_W), .CNT_W(CNT_W), .ON_TICKS(ON_TICKS)) u_level (
    .fb_code  (fb_code_i),
    .on_ticks (on_ticks)
  );

  gpwm_latch #(.CNT_W(CNT_W), .CHARGE(CHARGE), .BLANK(BLANK)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .on_ticks (on_ticks),
    .ilim_i   (ilim_i),
    .en_i     (en_i),
    .q_o      (latch_q)
  );

  assign cyc_start_o = rst_n && (cnt_q == CHG_C);
  assign gate_o      = latch_q && en_i;

  // R3: a pulse can only begin together with the strobe
  assert_rise_at_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> cyc_start_o);
  // R8: outputs idle under reset
  always_comb begin
    if (!rst_n) assert_reset_idle_R8: assert (!gate_o && !cyc_start_o);
  end
endmodule

// File: tb/gpwm_top_tb.sv
module gpwm_top_tb;
  localparam time CLK_PER = 10ns;
  localparam int  PER     = 1000;
  localparam int  CHG     = 280;
  localparam int  ON_MAX  = PER - CHG;
  localparam int  BLK     = 20;
  localparam int  NEVER   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [7:0] fb_code = 8'd0;
  logic       ilim = 1'b0;
  logic       gate_o;
  logic       cyc_start_o;

  int n_run = 0;
  int n_fail = 0;

  gpwm_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .fb_code_i   (fb_code),
    .ilim_i      (ilim),
    .gate_o      (gate_o),
    .cyc_start_o (cyc_start_o)
  );

  always #(CLK_PER / 2) clk = ~clk;

  function automatic int exp_on(input int f);
    return ((255 - f) * ON_MAX) / 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one period from a strobe; inputs follow a schedule by tick index
  task automatic run_period(input int fa, input int t1, input int fbb, input int t2,
                            input int fc, input int ils, input int ile,
                            input int ens, input int ene,
                            output int hi, output int pulses, output int chg_hi,
                            output int strobes, output int waited);
    int prev;
    fb_code = 8'(fa);
    ilim    = (ils < 0);
    en      = 1'b1;
    waited  = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!cyc_start_o);
    hi = 0; pulses = 0; chg_hi = 0; strobes = 0; prev = 0;
    for (int i = 0; i < PER; i++) begin
      if (i > 0) @(negedge clk);
      if (gate_o) begin
        hi++;
        if (prev == 0) pulses++;
        if (i >= ON_MAX) chg_hi++;
      end
      if (cyc_start_o) strobes++;
      prev    = int'(gate_o);
      fb_code = 8'(i >= t2 ? fc : (i >= t1 ? fbb : fa));
      ilim    = (i >= ils) && (i < ile);
      en      = !((i >= ens) && (i < ene));
      if (i == ens) begin
        #1;
        chk(gate_o == 1'b0, "R7 enable low drops gate in same tick", int'(gate_o), 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    int hi, pl, ch, st, wt, e;
    int codes[$];
    repeat (3) @(negedge clk);
    chk(gate_o == 1'b0, "R8 gate low in reset", int'(gate_o), 0);
    chk(cyc_start_o == 1'b0, "R8 strobe low in reset", int'(cyc_start_o), 0);
    rst_n = 1'b1;

    // R3 / R2 / R1 sweep over feedback codes
    for (int c = 0; c <= 255; c += 3) codes.push_back(c);
    codes.push_back(1);
    codes.push_back(254);
    codes.push_back(128);
    for (int k = 0; k < codes.size(); k++) begin
      run_period(codes[k], NEVER, 0, NEVER, 0, NEVER, NEVER, NEVER, NEVER,
                 hi, pl, ch, st, wt);
      e = exp_on(codes[k]);
      chk(hi == e, $sformatf("R3 on-time code %0d", codes[k]), hi, e);
      chk(ch == 0, "R2 no conduction in charge segment", ch, 0);
      chk(pl == (e > 0 ? 1 : 0), "R4 pulse count per period", pl, (e > 0 ? 1 : 0));
      chk(st == 1, "R1 one strobe per period", st, 1);
      if (k > 0) chk(wt == 1, "R1 strobe spacing 1000 ticks", wt, 1);
    end

    // R2 max duty with code 0
    run_period(0, NEVER, 0, NEVER, 0, NEVER, NEVER, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == ON_MAX, "R2 max pulse 720 ticks", hi, ON_MAX);

    // R4 code raised to peak mid-pulse, then lowered back: no second pulse
    run_period(0, 100, 255, 300, 0, NEVER, NEVER, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == 101, "R4 pulse ended by code change", hi, 101);
    chk(pl == 1, "R4 no second pulse after code lowered", pl, 1);

    // R3 code raised partway: ends at new crossing
    run_period(128, 50, 200, NEVER, 0, NEVER, NEVER, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == exp_on(200), "R3 crossing follows new code", hi, exp_on(200));

    // R5 unblanked current limit, short flag
    run_period(0, NEVER, 0, NEVER, 0, 300, 310, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == 301, "R5 current limit ends pulse", hi, 301);
    chk(pl == 1, "R5 stays off after limit clears", pl, 1);

    // R6 flag held all period
    run_period(0, NEVER, 0, NEVER, 0, -1, NEVER, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == BLK + 1, "R6 held limit gives blank+1 pulse", hi, BLK + 1);

    // R6 flag only inside blank window: ignored
    run_period(0, NEVER, 0, NEVER, 0, 5, 15, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == ON_MAX, "R6 limit inside blank ignored", hi, ON_MAX);

    // R6 boundary: last blanked tick and first unblanked tick
    run_period(0, NEVER, 0, NEVER, 0, 19, 21, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == BLK + 1, "R6 first unblanked tick acts", hi, BLK + 1);
    run_period(0, NEVER, 0, NEVER, 0, 19, 20, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == ON_MAX, "R6 last blanked tick ignored", hi, ON_MAX);

    // R6 pulse shorter than blank with held limit
    run_period(250, NEVER, 0, NEVER, 0, -1, NEVER, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == exp_on(250), "R6 code ends pulse before blank", hi, exp_on(250));

    // R7 enable drop and return mid-pulse
    run_period(0, NEVER, 0, NEVER, 0, NEVER, NEVER, 200, 300, hi, pl, ch, st, wt);
    chk(hi == 201, "R7 enable low ends pulse", hi, 201);
    chk(pl == 1, "R7 no resume after enable returns", pl, 1);
    run_period(0, NEVER, 0, NEVER, 0, NEVER, NEVER, NEVER, NEVER, hi, pl, ch, st, wt);
    chk(hi == ON_MAX, "R7 full pulse next period", hi, ON_MAX);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule